// File: doc/BRIEF.md
# Directory Coherence Home Controller

The block is the home-node side of a directory-based cache coherence scheme. It owns a fixed range of memory blocks and, for each one, keeps a coherence state and a bit vector naming the processors that hold a copy. Processors send it read misses, write misses and write-backs over an in-order network; the controller answers with data replies. To keep the sharer set consistent it also sends invalidates to holders of a shared copy and fetch or fetch-and-invalidate requests to the single holder of a modified copy.

One request is handled at a time. Requests that the directory can answer from memory are accepted back to back, and the reply leaves one cycle after acceptance. When copies must be invalidated first, or the current owner must return the block, the controller drops its ready signal until the reply has been issued. Outgoing messages leave at most one per cycle on a single message port, and the owner's data comes back on a separate response input.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is Uncached with an empty sharer set and zero data, `req_ready` is 1 and `msg_valid` is 0.
- R2: A read miss (`req_type` 0) to an Uncached block produces, one cycle after acceptance, a data reply (`msg_type` 3) to the requester carrying the stored block data. The block becomes Shared with only the requester in its sharer set.
- R3: A write miss (`req_type` 1) to an Uncached block produces a data reply to the requester one cycle after acceptance. The block becomes Exclusive with the requester as owner.
- R4: A read miss to a Shared block replies with the stored data one cycle after acceptance and adds the requester to the sharer set.
- R5: A write miss to a Shared block sends one invalidate (`msg_type` 0) per cycle, starting the cycle after the first message slot, to every sharer other than the requester, in ascending processor index. It then sends a data reply with the stored data, and the block becomes Exclusive with only the requester.
- R6: A read miss to an Exclusive block sends a fetch (`msg_type` 1) to the owner. When `rsp_valid` arrives the returned data is written to memory and replied to the requester, and the block becomes Shared holding both the old owner and the requester.
- R7: A write miss to an Exclusive block sends a fetch-and-invalidate (`msg_type` 2) to the owner. The returned data is replied to the requester, and the block stays Exclusive with the requester as the only owner.
- R8: A write-back (`req_type` 2) to an Exclusive block stores `req_data` in memory, empties the sharer set, makes the block Uncached and emits no message.
- R9: A write-back to a block that is not Exclusive, and any request with `req_type` 3, has no effect on data or directory state and emits no message.
- R10: `req_ready` is low from the cycle after a multi-message request is accepted until the cycle after its data reply. Every message names the request's block on `msg_blk`, and for a data reply the requester on `msg_dest`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Incoming request present |
| req_ready | output | 1 | Controller can accept a request |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 ignored |
| req_pid | input | PID_W | Requesting processor |
| req_blk | input | BLK_W | Block index |
| req_data | input | DATA_W | Write-back data |
| rsp_valid | input | 1 | Owner's data returned after fetch |
| rsp_data | input | DATA_W | Owner's block data |
| msg_valid | output | 1 | Outgoing message present |
| msg_type | output | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply |
| msg_dest | output | PID_W | Destination processor |
| msg_blk | output | BLK_W | Block the message concerns |
| msg_data | output | DATA_W | Data for a reply |

## Verification
Directed sequences walk one block through every state change. They include a write miss to a shared block whose sharer set contains the requester, which shows whether the requester is skipped and whether the invalidate order is ascending. A stray write-back to an uncached block followed by a read separates an ignored write from a stored one. Random traffic then runs over few blocks, with write-backs issued by the true owner, so read misses hit all three states repeatedly. This traffic tells apart an old owner that is kept as a sharer after a fetch from one that is dropped, because that shows up in later invalidate lists.

// File: rtl/dhc_pkg.sv
// Shared types and message codes for the directory home controller.
// Assumes two-bit request and message type fields on the ports.
package dhc_pkg;
    typedef enum logic [1:0] {
        DIR_UNC = 2'd0,
        DIR_SHR = 2'd1,
        DIR_EXC = 2'd2
    } dir_state_e;

    typedef enum logic [1:0] {
        CTL_IDLE  = 2'd0,
        CTL_INVAL = 2'd1,
        CTL_WAIT  = 2'd2
    } ctl_state_e;

    localparam logic [1:0] REQ_RD = 2'd0;
    localparam logic [1:0] REQ_WR = 2'd1;
    localparam logic [1:0] REQ_WB = 2'd2;

    localparam logic [1:0] MSG_INV   = 2'd0;
    localparam logic [1:0] MSG_FETCH = 2'd1;
    localparam logic [1:0] MSG_FINV  = 2'd2;
    localparam logic [1:0] MSG_REPLY = 2'd3;
endpackage

// File: rtl/dhc_dir_store.sv
// Per-block directory entries: coherence state plus sharer bit vector.
// Combinational read port, one synchronous write port; reset clears all.
module dhc_dir_store
    import dhc_pkg::*;
#(
    parameter int NBLK  = 8,
    parameter int NPROC = 4,
    localparam int BLK_W = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] blk,
    output dir_state_e       rd_state,
    output logic [NPROC-1:0] rd_sharers,
    input  logic             wr_en,
    input  dir_state_e       wr_state,
    input  logic [NPROC-1:0] wr_sharers
);
    dir_state_e       st_q [NBLK];
    logic [NPROC-1:0] sh_q [NBLK];

    // Read the addressed entry.
    assign rd_state   = st_q[blk];
    assign rd_sharers = sh_q[blk];

    // Reset every entry to Uncached, otherwise apply the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBLK; i++) begin
                st_q[i] <= DIR_UNC;
                sh_q[i] <= '0;
            end
        end else if (wr_en) begin
            st_q[blk] <= wr_state;
            sh_q[blk] <= wr_sharers;
        end
    end
endmodule

// File: rtl/dhc_data_store.sv
// Home memory for the block range: one word per block, reset to zero.
module dhc_data_store #(
    parameter int NBLK   = 8,
    parameter int DATA_W = 16,
    localparam int BLK_W = $clog2(NBLK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BLK_W-1:0]  blk,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] mem_q [NBLK];

    // Read the addressed word.
    assign rd_data = mem_q[blk];

    // Clear on reset, otherwise store the written word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBLK; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[blk] <= wr_data;
        end
    end
endmodule

// File: rtl/dhc_lowest_bit.sv
// Priority encoder: index of the lowest set bit of a vector.
module dhc_lowest_bit #(
    parameter int WIDTH = 4,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan high to low so the lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dir_home_ctrl.sv
// Home directory controller. Serves one request at a time; answers from
// memory where it can, otherwise invalidates sharers (ascending index,
// requester skipped) or fetches from the owner before replying.
// Assumes an in-order network and an output that never stalls.
module dir_home_ctrl
    import dhc_pkg::*;
#(
    parameter int NPROC  = 4,
    parameter int NBLK   = 8,
    parameter int DATA_W = 16,
    localparam int PID_W = $clog2(NPROC),
    localparam int BLK_W = $clog2(NBLK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_type,
    input  logic [PID_W-1:0]  req_pid,
    input  logic [BLK_W-1:0]  req_blk,
    input  logic [DATA_W-1:0] req_data,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              msg_valid,
    output logic [1:0]        msg_type,
    output logic [PID_W-1:0]  msg_dest,
    output logic [BLK_W-1:0]  msg_blk,
    output logic [DATA_W-1:0] msg_data
);
    ctl_state_e        ctl_q, ctl_n;
    logic [PID_W-1:0]  cur_pid_q;
    logic [BLK_W-1:0]  cur_blk_q;
    logic              cur_wr_q;
    logic [NPROC-1:0]  pend_q, pend_n;

    logic [BLK_W-1:0]  sel_blk;
    logic [PID_W-1:0]  sel_pid;
    logic [NPROC-1:0]  sel_bit;
    dir_state_e        rd_state, wr_state;
    logic [NPROC-1:0]  rd_sharers, wr_sharers, scan_vec;
    logic              dir_we, mem_we, scan_found;
    logic [PID_W-1:0]  scan_idx;
    logic [DATA_W-1:0] mem_rdata, mem_wdata;

    logic              mv_n;
    logic [1:0]        mt_n;
    logic [PID_W-1:0]  md_n;
    logic [DATA_W-1:0] mdat_n;

    // Address and requester come from the port when idle, else from the latch.
    assign sel_blk   = (ctl_q == CTL_IDLE) ? req_blk : cur_blk_q;
    assign sel_pid   = (ctl_q == CTL_IDLE) ? req_pid : cur_pid_q;
    assign sel_bit   = NPROC'(1) << sel_pid;
    assign scan_vec  = (ctl_q == CTL_INVAL) ? pend_q : rd_sharers;
    assign req_ready = (ctl_q == CTL_IDLE);

    dhc_dir_store #(.NBLK(NBLK), .NPROC(NPROC)) u_dir (
        .clk(clk), .rst_n(rst_n), .blk(sel_blk),
        .rd_state(rd_state), .rd_sharers(rd_sharers),
        .wr_en(dir_we), .wr_state(wr_state), .wr_sharers(wr_sharers)
    );

    dhc_data_store #(.NBLK(NBLK), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .blk(sel_blk),
        .rd_data(mem_rdata), .wr_en(mem_we), .wr_data(mem_wdata)
    );

    dhc_lowest_bit #(.WIDTH(NPROC)) u_scan (
        .vec(scan_vec), .found(scan_found), .idx(scan_idx)
    );

    // Decide directory update, memory write and next message.
    always_comb begin
        ctl_n      = ctl_q;
        pend_n     = pend_q;
        dir_we     = 1'b0;
        wr_state   = rd_state;
        wr_sharers = rd_sharers;
        mem_we     = 1'b0;
        mem_wdata  = req_data;
        mv_n       = 1'b0;
        mt_n       = MSG_REPLY;
        md_n       = sel_pid;
        mdat_n     = mem_rdata;
        unique case (ctl_q)
            CTL_IDLE: if (req_valid) begin
                unique case (rd_state)
                    DIR_UNC: if (req_type == REQ_RD || req_type == REQ_WR) begin
                        dir_we     = 1'b1;
                        wr_state   = (req_type == REQ_RD) ? DIR_SHR : DIR_EXC;
                        wr_sharers = sel_bit;
                        mv_n       = 1'b1;
                    end
                    DIR_SHR: if (req_type == REQ_RD) begin
                        dir_we     = 1'b1;
                        wr_sharers = rd_sharers | sel_bit;
                        mv_n       = 1'b1;
                    end else if (req_type == REQ_WR) begin
                        pend_n = rd_sharers & ~sel_bit;
                        ctl_n  = CTL_INVAL;
                    end
                    DIR_EXC: if (req_type == REQ_RD || req_type == REQ_WR) begin
                        mv_n  = 1'b1;
                        mt_n  = (req_type == REQ_RD) ? MSG_FETCH : MSG_FINV;
                        md_n  = scan_idx;
                        ctl_n = CTL_WAIT;
                    end else if (req_type == REQ_WB) begin
                        mem_we     = 1'b1;
                        dir_we     = 1'b1;
                        wr_state   = DIR_UNC;
                        wr_sharers = '0;
                    end
                    default: ;
                endcase
            end
            CTL_INVAL: begin
                mv_n = 1'b1;
                if (scan_found) begin
                    mt_n   = MSG_INV;
                    md_n   = scan_idx;
                    pend_n = pend_q & ~(NPROC'(1) << scan_idx);
                end else begin
                    dir_we     = 1'b1;
                    wr_state   = DIR_EXC;
                    wr_sharers = sel_bit;
                    ctl_n      = CTL_IDLE;
                end
            end
            CTL_WAIT: if (rsp_valid) begin
                mem_we     = 1'b1;
                mem_wdata  = rsp_data;
                dir_we     = 1'b1;
                wr_state   = cur_wr_q ? DIR_EXC : DIR_SHR;
                wr_sharers = cur_wr_q ? sel_bit : (rd_sharers | sel_bit);
                mv_n       = 1'b1;
                mdat_n     = rsp_data;
                ctl_n      = CTL_IDLE;
            end
            default: ctl_n = CTL_IDLE;
        endcase
    end

    // Control state, request latch and registered message outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q     <= CTL_IDLE;
            pend_q    <= '0;
            cur_pid_q <= '0;
            cur_blk_q <= '0;
            cur_wr_q  <= 1'b0;
            msg_valid <= 1'b0;
            msg_type  <= MSG_REPLY;
            msg_dest  <= '0;
            msg_blk   <= '0;
            msg_data  <= '0;
        end else begin
            ctl_q  <= ctl_n;
            pend_q <= pend_n;
            if (req_ready && req_valid) begin
                cur_pid_q <= req_pid;
                cur_blk_q <= req_blk;
                cur_wr_q  <= (req_type == REQ_WR);
            end
            msg_valid <= mv_n;
            msg_type  <= mt_n;
            msg_dest  <= md_n;
            msg_blk   <= sel_blk;
            msg_data  <= (mt_n == MSG_REPLY) ? mdat_n : '0;
        end
    end
endmodule

// File: rtl/dhc_checker.sv
// Port-level temporal checks for the directory home controller.
module dhc_checker #(
    parameter int PID_W  = 2,
    parameter int BLK_W  = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_type,
    input logic       msg_valid,
    input logic [1:0] msg_type
);
    // R5
    inval_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_type == 2'd0) |-> !req_ready);

    // R5
    inval_followed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_type == 2'd0) |=> msg_valid);

    // R6
    fetch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (msg_type == 2'd1 || msg_type == 2'd2)) |-> !req_ready);

    // R8
    wb_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_type == 2'd2) |=> !msg_valid);

    // R2
    read_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_type == 2'd0) |=> msg_valid);

    // R10
    write_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_type == 2'd1) |=> (msg_valid || !req_ready));
endmodule

bind dir_home_ctrl dhc_checker #(.PID_W(PID_W), .BLK_W(BLK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .msg_valid(msg_valid), .msg_type(msg_type)
);

// File: tb/tb_dir_home_ctrl.sv
// Self-checking bench: directed sequences then seeded random traffic
// against a reference directory model kept in the bench.
module tb_dir_home_ctrl;
    localparam int NPROC  = 4;
    localparam int NBLK   = 8;
    localparam int DATA_W = 16;
    localparam int PID_W  = $clog2(NPROC);
    localparam int BLK_W  = $clog2(NBLK);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_type = '0;
    logic [PID_W-1:0]  req_pid = '0;
    logic [BLK_W-1:0]  req_blk = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic              rsp_valid = 1'b0;
    logic [DATA_W-1:0] rsp_data = '0;
    logic              msg_valid;
    logic [1:0]        msg_type;
    logic [PID_W-1:0]  msg_dest;
    logic [BLK_W-1:0]  msg_blk;
    logic [DATA_W-1:0] msg_data;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    // model: 0 uncached, 1 shared, 2 exclusive
    int               m_state [NBLK];
    logic [NPROC-1:0] m_sh    [NBLK];
    logic [DATA_W-1:0] m_mem  [NBLK];

    logic [1:0]        e_type [NPROC+2];
    int                e_dest [NPROC+2];
    logic [DATA_W-1:0] e_data [NPROC+2];
    int                n_exp;

    dir_home_ctrl #(.NPROC(NPROC), .NBLK(NBLK), .DATA_W(DATA_W)) dut (.*);

    always #2 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string tag_for(input int st, input logic [1:0] t);
        if (t == 2'd2 || t == 2'd3) return "R9";
        if (st == 0) return (t == 2'd0) ? "R2" : "R3";
        if (st == 1) return (t == 2'd0) ? "R4" : "R5";
        return (t == 2'd0) ? "R6" : "R7";
    endfunction

    function automatic int owner_of(input logic [NPROC-1:0] v);
        for (int i = 0; i < NPROC; i++) if (v[i]) return i;
        return 0;
    endfunction

    // Issue one request, build the expected message list, and compare.
    task automatic run_req(input logic [1:0] t, input int pid, input int blk,
                           input logic [DATA_W-1:0] wdat);
        int st = m_state[blk];
        string tag;
        logic [DATA_W-1:0] rdat = DATA_W'($urandom);
        int got = 0;
        int cyc = 0;
        tag = (t == 2'd2 && st == 2) ? "R8" : tag_for(st, t);
        n_exp = 0;
        if (t == 2'd0 || t == 2'd1) begin
            if (st == 0) begin
                e_type[0] = 2'd3; e_dest[0] = pid; e_data[0] = m_mem[blk]; n_exp = 1;
                m_state[blk] = (t == 2'd0) ? 1 : 2;
                m_sh[blk] = NPROC'(1) << pid;
            end else if (st == 1 && t == 2'd0) begin
                e_type[0] = 2'd3; e_dest[0] = pid; e_data[0] = m_mem[blk]; n_exp = 1;
                m_sh[blk] |= NPROC'(1) << pid;
            end else if (st == 1) begin
                for (int i = 0; i < NPROC; i++) if (m_sh[blk][i] && i != pid) begin
                    e_type[n_exp] = 2'd0; e_dest[n_exp] = i; e_data[n_exp] = '0; n_exp++;
                end
                e_type[n_exp] = 2'd3; e_dest[n_exp] = pid; e_data[n_exp] = m_mem[blk]; n_exp++;
                m_state[blk] = 2;
                m_sh[blk] = NPROC'(1) << pid;
            end else begin
                e_type[0] = (t == 2'd0) ? 2'd1 : 2'd2; e_dest[0] = owner_of(m_sh[blk]); e_data[0] = '0;
                e_type[1] = 2'd3; e_dest[1] = pid; e_data[1] = rdat; n_exp = 2;
                m_mem[blk] = rdat;
                if (t == 2'd0) begin
                    m_state[blk] = 1; m_sh[blk] |= NPROC'(1) << pid;
                end else begin
                    m_sh[blk] = NPROC'(1) << pid;
                end
            end
        end else if (t == 2'd2 && st == 2) begin
            m_mem[blk] = wdat; m_state[blk] = 0; m_sh[blk] = '0;
        end

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_type = t; req_pid = PID_W'(pid);
        req_blk = BLK_W'(blk); req_data = wdat;
        @(negedge clk);
        req_valid = 1'b0;
        while (got < n_exp && cyc < 3 * NPROC + 10) begin
            rsp_valid = 1'b0;
            if (msg_valid) begin
                check(msg_type == e_type[got], tag, msg_type, e_type[got]);
                check(int'(msg_dest) == e_dest[got], tag, msg_dest, e_dest[got]);
                check(int'(msg_blk) == blk, "R10", msg_blk, blk);
                if (e_type[got] == 2'd3)
                    check(msg_data == e_data[got], tag, msg_data, e_data[got]);
                if (msg_type != 2'd3)
                    check(req_ready == 1'b0, "R10", req_ready, 0);
                if (msg_type == 2'd1 || msg_type == 2'd2) begin
                    rsp_valid = 1'b1; rsp_data = rdat;
                end
                got++;
            end
            @(negedge clk);
            cyc++;
        end
        rsp_valid = 1'b0;
        check(got == n_exp, tag, got, n_exp);
        check(msg_valid == 1'b0, tag, msg_valid, 0);
        check(req_ready == 1'b1, "R10", req_ready, 1);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        for (int i = 0; i < NBLK; i++) begin
            m_state[i] = 0; m_sh[i] = '0; m_mem[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state at the ports
        check(req_ready == 1'b1, "R1", req_ready, 1);
        check(msg_valid == 1'b0, "R1", msg_valid, 0);

        // Directed walk of block 0 (R1 data zero, R2..R9)
        run_req(2'd0, 0, 0, '0);          // R2 uncached read -> zero data
        run_req(2'd1, 1, 0, '0);          // R5 invalidate p0 then reply
        run_req(2'd0, 2, 0, '0);          // R6 fetch from p1
        run_req(2'd1, 3, 0, '0);          // R5 invalidates p1 then p2 (old owner kept)
        run_req(2'd2, 3, 0, 16'hBEEF);    // R8 owner write-back
        run_req(2'd2, 1, 0, 16'h1111);    // R9 stray write-back ignored
        run_req(2'd3, 1, 0, 16'h2222);    // R9 reserved type ignored
        run_req(2'd0, 0, 0, '0);          // R2 reply carries BEEF
        // Block 1: requester already a sharer is skipped (R5)
        run_req(2'd0, 0, 1, '0);          // R2
        run_req(2'd0, 2, 1, '0);          // R4
        run_req(2'd0, 1, 1, '0);          // R4
        run_req(2'd1, 2, 1, '0);          // R5 invalidates 0,1 only
        // Block 2: exclusive write transfer (R3, R7)
        run_req(2'd1, 0, 2, '0);          // R3
        run_req(2'd1, 3, 2, '0);          // R7 fetch-invalidate p0
        run_req(2'd0, 3, 2, '0);          // R6 owner rereads

        // Random traffic over three blocks
        for (int n = 0; n < 400; n++) begin
            int blk = $urandom_range(2, 0);
            int pid = $urandom_range(NPROC - 1, 0);
            int r   = $urandom_range(9, 0);
            logic [1:0] t = (r < 4) ? 2'd0 : (r < 7) ? 2'd1 : (r < 9) ? 2'd2 : 2'd3;
            if (t == 2'd2 && m_state[blk] == 2) pid = owner_of(m_sh[blk]);
            run_req(t, pid, blk, DATA_W'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule